// File: doc/BRIEF.md
# Per-Orbit Sample Value Histogram

This block counts how often each 12-bit sample value occurs during one orbit acquisition, which shows the spread of the digitised beam data. A sample is counted only when it is valid, not masked, and flagged in range. Each counted sample adds one to the bin selected by its value. Bins stop at their maximum count and do not wrap.

Two histogram banks alternate. One bank collects the current orbit. At the orbit boundary it becomes the readout bank and the other, already cleared, bank starts collecting. A reader fetches bins from the readout bank through a simple address/data port. When the reader is done it pulses a release strobe, and the block then wipes that bank in the background so it can take the next orbit. After reset, both banks are wiped before any sample is counted.

Top module: `orbit_histogram`

## Requirements
- R1: Each counted sample increases the bin whose index equals its 12-bit value by exactly one. There are 4096 bins per histogram.
- R2: A sample is counted only when smp_valid=1, smp_mask=0 and smp_in_range=1 in the same cycle. Any other combination leaves every bin unchanged.
- R3: Samples of the same value on consecutive cycles, or separated by one other value, are each counted. None is lost.
- R4: A bin that holds the all-ones count (2^CNT_W-1) stays there when further samples of its value arrive.
- R5: An accepted orbit_end ends the current histogram, and a sample counted in the same cycle belongs to the ending histogram. hist_ready rises two clock edges after the edge that samples orbit_end.
- R6: hist_ready stays high until rd_release is sampled high. It is low from the next edge on, and a rd_release while hist_ready is low has no effect.
- R7: An orbit_end that arrives while the previous histogram is still held or being cleared is ignored. Counting then continues into the same histogram.
- R8: After reset, filling stays low for 2*4096 clock edges while both banks are zeroed. Samples and orbit_end presented during this time are ignored.
- R9: During reset, filling and hist_ready are low.
- R10: rd_data returns, one edge after rd_addr is sampled, the count held in the readout bank at that address. A bank released earlier reads zero in every bin it did not count in its new orbit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bunch slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample was strobed in this slot |
| smp_mask | input | 1 | Slot excluded by the bunch mask |
| smp_in_range | input | 1 | Sample is within converter range |
| smp_value | input | DATA_W | Sample value, used as the bin index |
| orbit_end | input | 1 | Orbit acquisition boundary pulse |
| rd_addr | input | DATA_W | Bin index to read from the readout bank |
| rd_release | input | 1 | Reader done; clear the readout bank |
| filling | output | 1 | Block is counting samples (initial wipe finished) |
| hist_ready | output | 1 | A completed histogram can be read |
| rd_data | output | CNT_W | Count of the addressed bin, one cycle after the address |

## Verification
The assertions watch the hand-over protocol on every cycle. They check that hist_ready only ever rises three samples after an orbit_end, stays up until a release, and drops right after one. They also check that filling never falls once set, and that an orbit_end seen while a histogram is held does not flip the collecting bank. The bin contents can only be shown by the bench's scenarios: gating by mask, range and valid, counting of repeated values through the forward path, saturation, merging of orbits when a boundary is refused, and zeroed bins after a bank is reused. The bench reads these back through the read port and compares them with its own histogram model.

// File: rtl/orbit_histogram.sv
module orbit_histogram #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_mask,
  input  logic              smp_in_range,
  input  logic [DATA_W-1:0] smp_value,
  input  logic              orbit_end,
  input  logic [DATA_W-1:0] rd_addr,
  input  logic              rd_release,
  output logic              filling,
  output logic              hist_ready,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int BINS = 1 << DATA_W;
  localparam int AW   = DATA_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {B_FREE, B_DRAIN, B_HOLD, B_CLEAR} bank_st_t;

  logic [CNT_W-1:0]  mem [0:2*BINS-1];
  logic              init_busy;
  logic [AW-1:0]     init_idx;
  logic              fill_bank;
  bank_st_t          oth_st;
  logic              drain_cnt;
  logic [DATA_W-1:0] clr_idx;
  logic              p1_vld, p2_vld;
  logic [AW-1:0]     p1_addr, p2_addr;
  logic [CNT_W-1:0]  p2_cnt;
  logic [CNT_W-1:0]  nv;
  logic              take, swap, fwd;

  assign filling    = ~init_busy;
  assign hist_ready = (oth_st == B_HOLD);
  assign take = filling & smp_valid & ~smp_mask & smp_in_range;
  assign swap = filling & orbit_end & (oth_st == B_FREE);
  assign fwd  = p2_vld & (p2_addr == p1_addr);
  assign nv   = (p2_cnt == CNT_MAX) ? p2_cnt : p2_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (init_busy) begin
      mem[init_idx] <= '0;
    end else begin
      if (p2_vld)
        mem[p2_addr] <= nv;
      if (oth_st == B_CLEAR)
        mem[{~fill_bank, clr_idx}] <= '0;
    end
    p2_cnt  <= fwd ? nv : mem[p1_addr];
    rd_data <= mem[{~fill_bank, rd_addr}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
      fill_bank <= 1'b0;
      oth_st    <= B_FREE;
      drain_cnt <= 1'b0;
      clr_idx   <= '0;
      p1_vld    <= 1'b0;
      p2_vld    <= 1'b0;
      p1_addr   <= '0;
      p2_addr   <= '0;
    end else begin
      if (init_busy) begin
        init_idx <= init_idx + 1'b1;
        if (init_idx == {AW{1'b1}})
          init_busy <= 1'b0;
      end
      p1_vld  <= take;
      p1_addr <= {fill_bank, smp_value};
      p2_vld  <= p1_vld;
      p2_addr <= p1_addr;
      case (oth_st)
        B_FREE: if (swap) begin
          fill_bank <= ~fill_bank;
          oth_st    <= B_DRAIN;
          drain_cnt <= 1'b1;
        end
        B_DRAIN: if (drain_cnt) drain_cnt <= 1'b0;
                 else oth_st <= B_HOLD;
        B_HOLD: if (rd_release) begin
          oth_st  <= B_CLEAR;
          clr_idx <= '0;
        end
        B_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == {DATA_W{1'b1}})
            oth_st <= B_FREE;
        end
        default: oth_st <= B_FREE;
      endcase
    end
  end
endmodule

// File: rtl/orbit_histogram_chk.sv
module orbit_histogram_chk (
  input logic clk,
  input logic rst_n,
  input logic orbit_end,
  input logic rd_release,
  input logic filling,
  input logic hist_ready,
  input logic fill_bank
);
  a_r9_ready_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !filling |-> !hist_ready);
  a_r8_fill_stays: assert property (@(posedge clk) disable iff (!rst_n)
    filling |=> filling);
  a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ready && !rd_release |=> hist_ready);
  a_r6_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ready && rd_release |=> !hist_ready);
  a_r7_blocked_swap: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ready && orbit_end |=> $stable(fill_bank));
  a_r5_ready_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hist_ready) |-> $past(orbit_end, 3));
endmodule

bind orbit_histogram orbit_histogram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .orbit_end(orbit_end), .rd_release(rd_release),
  .filling(filling), .hist_ready(hist_ready), .fill_bank(fill_bank)
);

// File: tb/orbit_histogram_bench.sv
module orbit_histogram_bench;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int BINS = 1 << DW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic smp_valid = 0, smp_mask = 0, smp_in_range = 0, orbit_end = 0, rd_release = 0;
  logic [DW-1:0] smp_value = '0, rd_addr = '0;
  logic filling, hist_ready;
  logic [CW-1:0] rd_data;

  orbit_histogram #(.DATA_W(DW), .CNT_W(CW)) u_orbit_histogram (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mask(smp_mask),
    .smp_in_range(smp_in_range), .smp_value(smp_value), .orbit_end(orbit_end),
    .rd_addr(rd_addr), .rd_release(rd_release), .filling(filling),
    .hist_ready(hist_ready), .rd_data(rd_data));

  int checks = 0, fails = 0;
  bit finished = 0;
  int cur [BINS];
  int held [BINS];
  int ecount = 0, ready_edge = 0, free_edge = 0;
  bit holding = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit m, bit r, int val, bit oe, int ra, bit rel);
    int pre;
    bit fill_pre, rdy_pre, free_pre;
    smp_valid = v; smp_mask = m; smp_in_range = r; smp_value = DW'(val);
    orbit_end = oe; rd_addr = DW'(ra); rd_release = rel;
    @(posedge clk);
    pre = ecount;
    fill_pre = pre >= 2*BINS;
    rdy_pre  = holding && pre >= ready_edge;
    free_pre = !holding && pre >= free_edge;
    ecount++;
    if (fill_pre && v && !m && r && cur[val] < CMAX) cur[val]++;
    if (fill_pre && oe && free_pre) begin
      held = cur;
      foreach (cur[i]) cur[i] = 0;
      holding = 1;
      ready_edge = ecount + 2;
    end
    if (rdy_pre && rel) begin
      holding = 0;
      free_edge = ecount + BINS;
    end
    @(negedge clk);
    chk(filling == (ecount >= 2*BINS), "R8 filling", filling, ecount >= 2*BINS);
    chk(hist_ready == (holding && ecount >= ready_edge), "R6 hist_ready",
        hist_ready, holding && ecount >= ready_edge);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic smp(int val, int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, val, 0, 0, 0);
  endtask

  task automatic read_chk(int a, string req);
    step(0, 0, 0, 0, 0, a, 0);
    chk(rd_data == CW'(held[a]), req, rd_data, held[a]);
  endtask

  initial begin
    foreach (cur[i]) begin cur[i] = 0; held[i] = 0; end
    repeat (3) @(negedge clk);
    chk(filling == 0, "R9 filling in reset", filling, 0);
    chk(hist_ready == 0, "R9 hist_ready in reset", hist_ready, 0);
    rst_n = 1'b1;
    // R8: samples during the wipe are ignored
    smp(50, 4);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(2*BINS);
    // orbit 1: gating, repeats, boundary sample (R1 R2 R3 R5)
    smp(5, 1);
    smp(100, 3);
    smp(100, 1); smp(200, 1); smp(100, 1);
    step(1, 1, 1, 300, 0, 0, 0);
    step(1, 0, 0, 301, 0, 0, 0);
    step(0, 0, 1, 302, 0, 0, 0);
    smp(4095, 2);
    smp(0, 1);
    step(1, 0, 1, 777, 1, 0, 0);
    idle(3);
    chk(hist_ready == 1, "R5 ready after boundary", hist_ready, 1);
    read_chk(100, "R3 repeated value bin");
    read_chk(200, "R1 bin 200");
    read_chk(5, "R1 bin 5");
    read_chk(300, "R2 masked sample");
    read_chk(301, "R2 out of range sample");
    read_chk(302, "R2 invalid sample");
    read_chk(4095, "R1 top bin");
    read_chk(0, "R1 bottom bin");
    read_chk(777, "R5 sample on boundary cycle");
    read_chk(50, "R8 sample during wipe");
    // orbit 2: refused boundary while held (R7)
    smp(10, 3);
    step(0, 0, 0, 0, 1, 0, 0);
    smp(10, 2); smp(11, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(5);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(BINS + 2);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(3);
    read_chk(10, "R7 merged bin");
    read_chk(11, "R7 bin 11");
    read_chk(100, "R10 other bank bin 100");
    // orbit 3: reused bank reads zero (R10)
    smp(12, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(BINS + 2);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(3);
    read_chk(100, "R10 reused bank bin 100");
    read_chk(4095, "R10 reused bank bin 4095");
    read_chk(12, "R10 new count");
    // orbit 4: saturation (R4)
    step(0, 0, 0, 0, 0, 0, 1);
    smp(2048, CMAX + 77);
    smp(2049, 1); smp(2048, 2); smp(2049, 1);
    idle(BINS);
    step(0, 0, 0, 0, 1, 0, 0);
    idle(3);
    read_chk(2048, "R4 saturated bin");
    read_chk(2049, "R3 interleaved bin");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule